// File: doc/BRIEF.md
# Nested-Loop Matrix Index Remapper

This block produces the operand offsets for a matrix multiply carried out as a stream of scalar multiply-accumulate operations. The result C has R rows and K columns and is built from A (R by N) and B (N by K), all stored row-major. Every step that the block hands out names one C element, one A element and one B element. The C offset serves as both the addend source and the destination of an unmodified four-operand multiply-accumulate. The arithmetic, the register file and any memory traffic are handled outside this block.

Software loads the three sizes, a nesting order for the three loops and one reverse flag per loop, then pulses `start`. The block checks the configuration and then either raises an error flag or emits the steps one at a time over a valid/ready port. The final step is marked, and the block then goes back to idle. The loops can have any size from 1 to 127 and can be nested in any of the six orders, but the total number of steps may not exceed 127.

Top module: `mm_index_remap`

## Requirements
- R1: For loop indices i (row, 0..R-1), j (column, 0..K-1) and n (inner, 0..N-1), a step carries C offset i*K+j, A offset i*N+n and B offset n*K+j. Sizes are any value in 1..127 and need not be powers of two.
- R2: `cfg_order` selects the nesting, listed outermost to innermost: 0 = i,j,n; 1 = i,n,j; 2 = j,i,n; 3 = j,n,i; 4 = n,i,j; 5 = n,j,i.
- R3: `cfg_rev` bit 0 reverses i, bit 1 reverses j and bit 2 reverses n. A reversed loop starts at its size minus one and counts down to zero.
- R4: The innermost loop moves on every transfer. An outer loop moves only when every loop inside it is at its end, and at that point the inner loops return to their start values.
- R5: A start with a zero size, a size product above 127, or `cfg_order` above 5 sets `cfg_err` and issues no steps. A start with a valid configuration clears `cfg_err`.
- R6: While `step_valid` is high and `step_ready` is low, the offsets and `step_last` hold steady and `step_valid` stays high.
- R7: `step_last` is high only on the final step. After that step transfers, `step_valid` goes low until the next start.
- R8: A `start` pulse received while a sequence is running has no effect on the step stream.
- R9: After reset, `step_valid` and `cfg_err` are low.
- R10: A configuration whose size product is exactly 127 is accepted and emits 127 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Captures the configuration fields below |
| cfg_rows | input | 7 | R, the number of result rows |
| cfg_cols | input | 7 | K, the number of result columns |
| cfg_inner | input | 7 | N, the length of the inner dot product |
| cfg_order | input | 3 | Loop nesting order code |
| cfg_rev | input | 3 | Per-loop reverse flags {n, j, i} |
| start | input | 1 | Begins a sequence when idle |
| cfg_err | output | 1 | The last start was rejected |
| step_valid | output | 1 | A step is offered |
| step_ready | input | 1 | Consumer accepts the step |
| step_c_off | output | 7 | Accumulator / destination offset |
| step_a_off | output | 7 | A element offset |
| step_b_off | output | 7 | B element offset |
| step_last | output | 1 | Final step of the sequence |

## Verification
A start pulse sampled at one edge makes `step_valid` and the first step visible after that same edge. For a rejected configuration, `cfg_err` rises at that edge instead and `step_valid` stays low. Each transfer at an edge shows the next step right after it, and the edge that takes the last step drops `step_valid`. The bench drives inputs shortly after each rising edge or on the falling edge. It samples at the falling edge, so every value is checked half a period after the edge that produced it. A scoreboard compares transfers in order, and stalls are checked against the values held from the previous sample.

// File: rtl/mmr_pkg.sv
// Shared widths and types for the matrix index remapper.
// Assumes that every size, offset and step count fits in IDX_W bits.
package mmr_pkg;
    localparam int IDX_W     = 7;
    localparam int MAX_STEPS = 127;
    localparam int NDIM      = 3;
    localparam int RANK_W    = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/mmr_cfg_check.sv
// Validates a remapper configuration and turns the nesting-order code into
// a rank for each dimension (0 = outermost, 2 = innermost).
// Assumes the dimensions are 0 = row, 1 = column, 2 = inner.
module mmr_cfg_check
    import mmr_pkg::*;
#(
    parameter int W     = IDX_W,
    parameter int LIMIT = MAX_STEPS
) (
    input  logic [W-1:0]                 rows,
    input  logic [W-1:0]                 cols,
    input  logic [W-1:0]                 inner,
    input  logic [2:0]                   order,
    output logic                         cfg_ok,
    output logic [NDIM-1:0][RANK_W-1:0]  rank
);
    localparam int PW = 3 * W;

    logic [PW-1:0] product;

    // Total number of steps the configuration asks for.
    always_comb product = PW'(rows) * PW'(cols) * PW'(inner);

    // Accept only nonzero sizes, a bounded product and a legal order code.
    always_comb begin
        cfg_ok = (rows != '0) && (cols != '0) && (inner != '0)
              && (product <= PW'(LIMIT)) && (order <= 3'd5);
    end

    // Rank of each dimension for the selected nesting order.
    always_comb begin
        case (order)
            3'd0:    rank = {2'd2, 2'd1, 2'd0};
            3'd1:    rank = {2'd1, 2'd2, 2'd0};
            3'd2:    rank = {2'd2, 2'd0, 2'd1};
            3'd3:    rank = {2'd1, 2'd0, 2'd2};
            3'd4:    rank = {2'd0, 2'd2, 2'd1};
            3'd5:    rank = {2'd0, 2'd1, 2'd2};
            default: rank = {2'd2, 2'd1, 2'd0};
        endcase
    end
endmodule

// File: rtl/mmr_dim_counter.sv
// One loop dimension: captures its size and direction on load, then steps
// up or down on each advance and wraps at its end.
// Assumes that load and adv are never high together and that size is nonzero at load.
module mmr_dim_counter
    import mmr_pkg::*;
#(
    parameter int W = IDX_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv,
    input  logic         active,
    input  logic [W-1:0] size,
    input  logic         rev,
    output logic [W-1:0] idx,
    output logic [W-1:0] size_q,
    output logic         at_end
);
    logic rev_q;

    // Loop end: zero when counting down, size minus one when counting up.
    always_comb at_end = rev_q ? (idx == '0) : (idx == size_q - W'(1));

    // Latch the dimension setup and step the index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            size_q <= W'(1);
            rev_q  <= 1'b0;
        end else if (load) begin
            size_q <= size;
            rev_q  <= rev;
            idx    <= rev ? size - W'(1) : '0;
        end else if (adv) begin
            if (at_end)     idx <= rev_q ? size_q - W'(1) : '0;
            else if (rev_q) idx <= idx - W'(1);
            else            idx <= idx + W'(1);
        end
    end

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx < size_q)); // R1

    AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && at_end && !load) |=> (idx == (rev_q ? size_q - W'(1) : '0))); // R3
endmodule

// File: rtl/mmr_offset_calc.sv
// Forms the C, A and B offsets of row-major matrices from the loop indices.
// Assumes that every true offset is below 2**W, so arithmetic modulo 2**W is exact.
module mmr_offset_calc
    import mmr_pkg::*;
#(
    parameter int W = IDX_W
) (
    input  logic [W-1:0] i_idx,
    input  logic [W-1:0] j_idx,
    input  logic [W-1:0] n_idx,
    input  logic [W-1:0] k_size,
    input  logic [W-1:0] n_size,
    output logic [W-1:0] c_off,
    output logic [W-1:0] a_off,
    output logic [W-1:0] b_off
);
    // Row-major offsets for the accumulator and the two sources.
    always_comb begin
        c_off = i_idx * k_size + j_idx;
        a_off = i_idx * n_size + n_idx;
        b_off = n_idx * k_size + j_idx;
    end
endmodule

// File: rtl/mm_index_remap.sv
// Top of the matrix index remapper. Holds the configuration, validates it on
// start, runs three nested loop counters in the selected order and offers one
// offset triple per step on a valid/ready port.
// Assumes that the consumer holds no step beyond its own ready signal.
module mm_index_remap
    import mmr_pkg::*;
#(
    parameter int W     = IDX_W,
    parameter int LIMIT = MAX_STEPS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_load,
    input  logic [W-1:0] cfg_rows,
    input  logic [W-1:0] cfg_cols,
    input  logic [W-1:0] cfg_inner,
    input  logic [2:0]   cfg_order,
    input  logic [2:0]   cfg_rev,
    input  logic         start,
    output logic         cfg_err,
    output logic         step_valid,
    input  logic         step_ready,
    output logic [W-1:0] step_c_off,
    output logic [W-1:0] step_a_off,
    output logic [W-1:0] step_b_off,
    output logic         step_last
);
    run_state_t                   state;
    logic [W-1:0]                 rows_q, cols_q, inner_q;
    logic [2:0]                   order_q, rev_q;
    logic                         cfg_ok;
    logic [NDIM-1:0][RANK_W-1:0]  rank_new, rank_q;
    logic [NDIM-1:0][W-1:0]       sizes_q;
    logic [NDIM-1:0][W-1:0]       idx;
    logic [NDIM-1:0][W-1:0]       dim_size;
    logic [NDIM-1:0]              at_end;
    logic [NDIM-1:0]              adv;
    logic                         launch, xfer, all_end;

    // Capture the configuration fields whenever software loads them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rows_q  <= W'(1);
            cols_q  <= W'(1);
            inner_q <= W'(1);
            order_q <= '0;
            rev_q   <= '0;
        end else if (cfg_load) begin
            rows_q  <= cfg_rows;
            cols_q  <= cfg_cols;
            inner_q <= cfg_inner;
            order_q <= cfg_order;
            rev_q   <= cfg_rev;
        end
    end

    mmr_cfg_check #(.W(W), .LIMIT(LIMIT)) u_check (
        .rows   (rows_q),
        .cols   (cols_q),
        .inner  (inner_q),
        .order  (order_q),
        .cfg_ok (cfg_ok),
        .rank   (rank_new)
    );

    // Decode the handshake events.
    always_comb begin
        launch     = (state == ST_IDLE) && start && cfg_ok;
        step_valid = (state == ST_RUN);
        xfer       = step_valid && step_ready;
        all_end    = &at_end;
        step_last  = step_valid && all_end;
    end

    // Sequence control and the rejection flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cfg_err <= 1'b0;
            rank_q  <= '0;
        end else if (state == ST_IDLE) begin
            if (start) begin
                cfg_err <= !cfg_ok;
                if (cfg_ok) begin
                    state  <= ST_RUN;
                    rank_q <= rank_new;
                end
            end
        end else if (xfer && all_end) begin
            state <= ST_IDLE;
        end
    end

    // A loop advances on a transfer when every loop nested inside it is at its end.
    always_comb begin
        for (int d = 0; d < NDIM; d++) begin
            adv[d] = xfer;
            for (int e = 0; e < NDIM; e++) begin
                if (e != d && rank_q[e] > rank_q[d]) adv[d] = adv[d] & at_end[e];
            end
        end
    end

    // Route each configured size to its dimension counter.
    always_comb sizes_q = {inner_q, cols_q, rows_q};

    for (genvar g = 0; g < NDIM; g++) begin : g_dim
        mmr_dim_counter #(.W(W)) u_dim (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (launch),
            .adv    (adv[g]),
            .active (step_valid),
            .size   (sizes_q[g]),
            .rev    (rev_q[g]),
            .idx    (idx[g]),
            .size_q (dim_size[g]),
            .at_end (at_end[g])
        );
    end

    mmr_offset_calc #(.W(W)) u_offs (
        .i_idx  (idx[0]),
        .j_idx  (idx[1]),
        .n_idx  (idx[2]),
        .k_size (dim_size[1]),
        .n_size (dim_size[2]),
        .c_off  (step_c_off),
        .a_off  (step_a_off),
        .b_off  (step_b_off)
    );

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !step_ready) |=> (step_valid && $stable(step_c_off)
            && $stable(step_a_off) && $stable(step_b_off) && $stable(step_last))); // R6

    AST_LAST_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && step_last) |=> !step_valid); // R7

    AST_ERR_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !step_valid); // R5

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && start && !(xfer && step_last)) |=> step_valid); // R8

    AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !step_last) |=> !($stable(step_c_off) && $stable(step_a_off)
            && $stable(step_b_off))); // R4
endmodule

// File: tb/mm_index_remap_tb.sv
// Scoreboard bench: a driver task queues the expected steps of each sequence,
// and a monitor pops them as transfers occur.
module mm_index_remap_tb;
    localparam int W = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_load = 1'b0;
    logic [W-1:0] cfg_rows = '0, cfg_cols = '0, cfg_inner = '0;
    logic [2:0]   cfg_order = '0, cfg_rev = '0;
    logic         start = 1'b0;
    logic         cfg_err, step_valid, step_last;
    logic         step_ready = 1'b0;
    logic [W-1:0] step_c_off, step_a_off, step_b_off;

    int           n_chk = 0;
    int           n_fail = 0;
    logic [21:0]  exp_q[$];
    int           stall_mode = 0;
    logic [7:0]   lfsr = 8'hA5;

    always #4 clk = ~clk;  // 125 MHz

    mm_index_remap u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_inner(cfg_inner),
        .cfg_order(cfg_order), .cfg_rev(cfg_rev), .start(start),
        .cfg_err(cfg_err), .step_valid(step_valid), .step_ready(step_ready),
        .step_c_off(step_c_off), .step_a_off(step_a_off),
        .step_b_off(step_b_off), .step_last(step_last)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Ready driver: always ready, or a pseudo-random stall pattern.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step_ready = (stall_mode == 0) ? 1'b1 : lfsr[0];
        end
    end

    // Monitor: compare transfers with the scoreboard and stalls with held values.
    logic        was_stall = 1'b0;
    logic [21:0] held;
    initial begin
        forever begin
            @(negedge clk);
            if (step_valid) begin
                if (was_stall)
                    check({step_last, step_c_off, step_a_off, step_b_off} == held,
                          "R6 hold", int'({step_c_off, step_a_off}), int'(held[20:7]));
                if (step_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8 unexpected step", int'(step_c_off), -1);
                    end else begin
                        logic [21:0] e;
                        e = exp_q.pop_front();
                        check(step_c_off == e[20:14], "R1 C offset", int'(step_c_off), int'(e[20:14]));
                        check(step_a_off == e[13:7],  "R2 A offset", int'(step_a_off), int'(e[13:7]));
                        check(step_b_off == e[6:0],   "R4 B offset", int'(step_b_off), int'(e[6:0]));
                        check(step_last == e[21],     "R7 last flag", int'(step_last), int'(e[21]));
                    end
                end
                was_stall = !step_ready;
                held = {step_last, step_c_off, step_a_off, step_b_off};
            end else begin
                was_stall = 1'b0;
            end
        end
    end

    function automatic int dim_at(input int ord, input int pos);
        int t[6][3] = '{'{0,1,2}, '{0,2,1}, '{1,0,2}, '{1,2,0}, '{2,0,1}, '{2,1,0}};
        return t[ord][pos];
    endfunction

    task automatic load_cfg(input int r, input int k, input int n, input int ord, input int rv);
        @(negedge clk);
        cfg_rows = W'(r); cfg_cols = W'(k); cfg_inner = W'(n);
        cfg_order = 3'(ord); cfg_rev = 3'(rv); cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // Driver: queue the expected steps, launch, optionally poke start mid-run.
    task automatic run_seq(input int r, input int k, input int n, input int ord,
                           input int rv, input int mode, input bit poke);
        int sz[3];
        int cyc;
        sz[0] = r; sz[1] = k; sz[2] = n;
        for (int p0 = 0; p0 < sz[dim_at(ord,0)]; p0++)
            for (int p1 = 0; p1 < sz[dim_at(ord,1)]; p1++)
                for (int p2 = 0; p2 < sz[dim_at(ord,2)]; p2++) begin
                    int ix[3];
                    int c, a, b;
                    bit lst;
                    ix[dim_at(ord,0)] = p0; ix[dim_at(ord,1)] = p1; ix[dim_at(ord,2)] = p2;
                    for (int d = 0; d < 3; d++)
                        if (rv[d]) ix[d] = sz[d] - 1 - ix[d];  // R3 reversed loops
                    c = ix[0]*k + ix[1]; a = ix[0]*n + ix[2]; b = ix[2]*k + ix[1];
                    lst = (p0 == sz[dim_at(ord,0)]-1) && (p1 == sz[dim_at(ord,1)]-1)
                       && (p2 == sz[dim_at(ord,2)]-1);
                    exp_q.push_back({lst, 7'(c), 7'(a), 7'(b)});
                end
        load_cfg(r, k, n, ord, rv);
        stall_mode = mode;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(cfg_err == 1'b0, "R5 valid cfg clears err", int'(cfg_err), 0);
        cyc = 0;
        do begin
            @(negedge clk);
            #1;
            cyc++;
            if (poke && cyc == 5) start = 1'b1;     // R8 start while running
            if (poke && cyc == 6) start = 1'b0;
        end while (exp_q.size() != 0);
        start = 1'b0;
        @(negedge clk);
        check(step_valid == 1'b0, "R7 idle after last", int'(step_valid), 0);
        @(negedge clk);
        check(step_valid == 1'b0, "R7 stays idle", int'(step_valid), 0);
    endtask

    task automatic bad_cfg(input int r, input int k, input int n, input int ord, input string why);
        load_cfg(r, k, n, ord, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(cfg_err == 1'b1, why, int'(cfg_err), 1);
        repeat (3) begin
            @(negedge clk);
            check(step_valid == 1'b0, "R5 no steps after reject", int'(step_valid), 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(step_valid == 1'b0, "R9 reset valid", int'(step_valid), 0);
        check(cfg_err == 1'b0, "R9 reset err", int'(cfg_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(step_valid == 1'b0, "R9 idle after reset", int'(step_valid), 0);

        run_seq(2, 3, 4, 0, 0, 0, 1'b0);        // R1 R2 R4 plain order
        run_seq(3, 2, 5, 5, 3'b101, 1, 1'b0);   // R2 R3 R6 reversed, stalls
        run_seq(7, 1, 3, 3, 3'b010, 1, 1'b0);   // R2 R3 odd sizes
        run_seq(3, 5, 2, 1, 3'b100, 0, 1'b1);   // R8 start mid-run
        run_seq(2, 4, 3, 2, 3'b011, 1, 1'b0);   // R2
        run_seq(3, 3, 3, 4, 3'b111, 0, 1'b0);   // R2 R3
        run_seq(1, 127, 1, 1, 3'b110, 1, 1'b0); // R10 product exactly 127

        bad_cfg(10, 13, 1, 0, "R5 product over limit");
        bad_cfg(4, 0, 3, 0, "R5 zero size");
        bad_cfg(2, 2, 2, 6, "R5 illegal order");
        run_seq(1, 1, 1, 0, 0, 0, 1'b0);        // R5 err cleared, single step

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule